// File: doc/BRIEF.md
# Interrupt Redirection Table Dispatcher

The dispatcher sits on the I/O side of an interrupt system. It has a parameterised number of interrupt input pins. Each pin has its own redirection entry that software programs through an indirect window: a select register chooses a register, and a data port reads or writes it. When a pin is asserted, the block records a pending request for that pin. It then scans the pending, unmasked pins and turns the entry of each one into a delivery message, offered on a valid/ready request channel.

Only one message is in flight at a time. After the message is taken, the block waits for a single-cycle response that either accepts or rejects it. An accept retires the pin's pending request. A reject leaves the request pending, so it is retried, marks the entry's delivery-status bit, and advances a counter of consecutive failures that raises a warning output once it exceeds five. Destination resolution and arbitration between receivers happen downstream and are not part of this block.

Back-pressure on the request channel: once `req_valid` is high, it stays high and the message fields stay unchanged until a cycle with `req_ready` high completes the transfer. Responses are sampled only while the block is awaiting one. Exactly one response must follow each transfer, and none may come at any other time.

Top module: `irq_redirector`

## Requirements
- R1: After reset, every entry is masked, so its low word reads 0x0001_0000 and its high word reads 0. The select register is 0x00, the ID is 0, `req_valid` is low and `stuck_warn` is low.
- R2: A cycle with `pin_in[n]` high sets pin n's pending flag. Asserting the pin again while the flag is set has no effect, so the pin produces exactly one accepted delivery.
- R3: A pending pin whose entry mask bit (low word bit 16) is 1 is never offered. Its pending flag is kept, and it is offered once software clears the mask.
- R4: When several pending pins are unmasked, the lowest-numbered pin is offered first.
- R5: The message fields come from the entry. `req_vec` is low bits [7:0], `req_dlv` is [10:8], `req_dmode` is [11], `req_pol` is [13], `req_trig` is [15], and `req_dest` is bits [31:24] of the high word. While `req_valid` is high and `req_ready` is low, the fields and `req_valid` hold.
- R6: An accepting response (`rsp_valid` with `rsp_accept`=1) clears the pending flag and clears the entry's delivery-status bit (low word bit 12). It also resets the failure counter, so `stuck_warn` is low in the following cycle.
- R7: A rejecting response (`rsp_valid` with `rsp_accept`=0) keeps the pin pending and re-offers it, sets delivery status to 1, and increments the failure counter. `stuck_warn` is high only while more than 5 consecutive rejects have been counted.
- R8: Select 0x00 holds a writable ID in bits [31:24] and reads 0 in all other bits. Select 0x01 reads the highest pin index in [23:16] and version code 0x11 in [7:0], which is 0x0017_0011 for 24 pins. Select 0x02 and unused selects read 0.
- R9: Entry n's low word is at select 0x10+2n and its high word at 0x11+2n. The delivery-status bit is read-only, and software writes to it are ignored.
- R10: At most one message is outstanding. No new `req_valid` appears between a transfer and its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Interrupt pin assertions, one per entry |
| sel_we | input | 1 | Load the window select from wdata[7:0] |
| data_we | input | 1 | Write wdata to the selected register |
| wdata | input | 32 | Window write data |
| rdata | output | 32 | Contents of the selected register |
| req_valid | output | 1 | Delivery message offered |
| req_ready | input | 1 | Downstream takes the message |
| req_dest | output | 8 | Destination field |
| req_dmode | output | 1 | Destination mode field |
| req_dlv | output | 3 | Delivery mode field |
| req_vec | output | 8 | Vector field |
| req_pol | output | 1 | Polarity field |
| req_trig | output | 1 | Trigger mode field |
| rsp_valid | input | 1 | Completion response present |
| rsp_accept | input | 1 | 1 = accepted, 0 = rejected |
| stuck_warn | output | 1 | More than 5 consecutive rejects |

## Verification
A pending flag that is lost or left set shows at the request port within two cycles of the next idle scan, as a missing or repeated message. A wrong scan order shows as the wrong vector on the first message of a simultaneous burst. A corrupted delivery-status bit or failure counter shows on the very next window read of the entry's low word, or on `stuck_warn` one cycle after the response. Field routing errors from the table to the message appear on the first offer from that entry.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  // Delivery message carried from the table to the request port.
  typedef struct packed {
    logic [7:0] dest;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vec;
    logic       pol;
    logic       trig;
  } irq_msg_t;

  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  // Bit positions inside an entry's low word.
  localparam int B_MASK  = 16;
  localparam int B_TRIG  = 15;
  localparam int B_POL   = 13;
  localparam int B_DSTAT = 12;
  localparam int B_DMODE = 11;

endpackage

// File: rtl/irq_entry_bank.sv
module irq_entry_bank
  import irq_redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERCODE = 8'h11,
  parameter int         IDX_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic             data_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [NPINS-1:0] mask_vec,
  input  logic [IDX_W-1:0] rd_idx,
  output irq_msg_t         rd_msg,
  input  logic             st_we,
  input  logic [IDX_W-1:0] st_idx,
  input  logic             st_val
);

  localparam logic [7:0] TOP_IDX = 8'(NPINS - 1);

  logic [7:0]  sel_q;
  logic [7:0]  id_q;
  logic [16:0] lo_q   [NPINS];
  logic [7:0]  dest_q [NPINS];
  logic        dstat_q[NPINS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SEL_ID;
      id_q  <= '0;
    end else begin
      if (sel_we) sel_q <= wdata[7:0];
      if (data_we && sel_q == SEL_ID) id_q <= wdata[31:24];
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    localparam logic [7:0] LO_SEL = 8'(16 + 2 * g);
    localparam logic [7:0] HI_SEL = 8'(17 + 2 * g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g]    <= 17'h1_0000;
        dest_q[g]  <= '0;
        dstat_q[g] <= 1'b0;
      end else begin
        if (data_we && sel_q == LO_SEL) lo_q[g] <= wdata[16:0];
        if (data_we && sel_q == HI_SEL) dest_q[g] <= wdata[31:24];
        if (st_we && st_idx == IDX_W'(g)) dstat_q[g] <= st_val;
      end
    end
    assign mask_vec[g] = lo_q[g][B_MASK];
  end

  always_comb begin
    rdata = '0;
    case (sel_q)
      SEL_ID:  rdata = {id_q, 24'h0};
      SEL_VER: rdata = {8'h00, TOP_IDX, 8'h00, VERCODE};
      SEL_ARB: rdata = '0;
      default: rdata = '0;
    endcase
    for (int i = 0; i < NPINS; i++) begin
      if (sel_q == 8'(16 + 2 * i))
        rdata = {15'h0, lo_q[i][16:13], dstat_q[i], lo_q[i][11:0]};
      if (sel_q == 8'(17 + 2 * i))
        rdata = {dest_q[i], 24'h0};
    end
  end

  always_comb begin
    rd_msg = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_msg.dest  = dest_q[i];
        rd_msg.dmode = lo_q[i][B_DMODE];
        rd_msg.dlv   = lo_q[i][10:8];
        rd_msg.vec   = lo_q[i][7:0];
        rd_msg.pol   = lo_q[i][B_POL];
        rd_msg.trig  = lo_q[i][B_TRIG];
      end
    end
  end

endmodule

// File: rtl/irq_pend_scan.sv
module irq_pend_scan #(
  parameter int NPINS = 24,
  parameter int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] mask_vec,
  input  logic             clr_we,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NPINS-1:0] pend_q,
  output logic             cand_v,
  output logic [IDX_W-1:0] cand_idx
);

  logic [NPINS-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    for (int i = 0; i < NPINS; i++)
      if (clr_we && clr_idx == IDX_W'(i)) clr_vec[i] = 1'b1;
  end

  // A set flag absorbs further assertions; only a retire clears it.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | pin_in;
  end

  // Walk downward so the lowest eligible index is the one kept.
  always_comb begin
    cand_v   = 1'b0;
    cand_idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (pend_q[i] && !mask_vec[i]) begin
        cand_v   = 1'b1;
        cand_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_dlv_ctl.sv
module irq_dlv_ctl
  import irq_redir_pkg::*;
#(
  parameter int NPINS       = 24,
  parameter int CNT_W       = 4,
  parameter int STUCK_LIMIT = 5,
  parameter int IDX_W       = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_v,
  input  logic [IDX_W-1:0] cand_idx,
  input  irq_msg_t         cand_msg,
  output logic             req_valid,
  input  logic             req_ready,
  output irq_msg_t         req_msg,
  input  logic             rsp_valid,
  input  logic             rsp_accept,
  output logic             clr_we,
  output logic             st_we,
  output logic             st_val,
  output logic [IDX_W-1:0] cur_idx,
  output logic             waiting,
  output logic             stuck_warn
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(STUCK_LIMIT);

  st_t              st_q;
  irq_msg_t         msg_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done;

  assign done = (st_q == S_WAIT) && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      msg_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cand_v) begin
          st_q  <= S_REQ;
          msg_q <= cand_msg;
          idx_q <= cand_idx;
        end
        S_REQ:  if (req_ready) st_q <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          st_q <= S_IDLE;
          if (rsp_accept)          cnt_q <= '0;
          else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_valid  = (st_q == S_REQ);
  assign req_msg    = msg_q;
  assign clr_we     = done && rsp_accept;
  assign st_we      = done;
  assign st_val     = !rsp_accept;
  assign cur_idx    = idx_q;
  assign waiting    = (st_q == S_WAIT);
  assign stuck_warn = (cnt_q > LIMIT);

endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int         NPINS       = 24,
  parameter logic [7:0] VERCODE     = 8'h11,
  parameter int         CNT_W       = 4,
  parameter int         STUCK_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             sel_we,
  input  logic             data_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [7:0]       req_dest,
  output logic             req_dmode,
  output logic [2:0]       req_dlv,
  output logic [7:0]       req_vec,
  output logic             req_pol,
  output logic             req_trig,
  input  logic             rsp_valid,
  input  logic             rsp_accept,
  output logic             stuck_warn
);

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [NPINS-1:0] mask_vec;
  logic [NPINS-1:0] pend_q;
  logic             cand_v;
  logic [IDX_W-1:0] cand_idx;
  logic [IDX_W-1:0] cur_idx;
  irq_msg_t         cand_msg;
  irq_msg_t         req_msg;
  logic             clr_we, st_we, st_val, waiting;

  irq_entry_bank #(.NPINS(NPINS), .VERCODE(VERCODE), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
    .wdata(wdata), .rdata(rdata), .mask_vec(mask_vec),
    .rd_idx(cand_idx), .rd_msg(cand_msg),
    .st_we(st_we), .st_idx(cur_idx), .st_val(st_val)
  );

  irq_pend_scan #(.NPINS(NPINS), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mask_vec(mask_vec),
    .clr_we(clr_we), .clr_idx(cur_idx), .pend_q(pend_q),
    .cand_v(cand_v), .cand_idx(cand_idx)
  );

  irq_dlv_ctl #(.NPINS(NPINS), .CNT_W(CNT_W), .STUCK_LIMIT(STUCK_LIMIT),
                .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cand_v(cand_v), .cand_idx(cand_idx),
    .cand_msg(cand_msg), .req_valid(req_valid), .req_ready(req_ready),
    .req_msg(req_msg), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
    .clr_we(clr_we), .st_we(st_we), .st_val(st_val), .cur_idx(cur_idx),
    .waiting(waiting), .stuck_warn(stuck_warn)
  );

  assign req_dest  = req_msg.dest;
  assign req_dmode = req_msg.dmode;
  assign req_dlv   = req_msg.dlv;
  assign req_vec   = req_msg.vec;
  assign req_pol   = req_msg.pol;
  assign req_trig  = req_msg.trig;

endmodule

// File: rtl/irq_redirector_chk.sv
module irq_redirector_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [7:0]       req_vec,
  input logic [7:0]       req_dest,
  input logic             rsp_valid,
  input logic             rsp_accept,
  input logic             stuck_warn,
  input logic [NPINS-1:0] pend_q,
  input logic             waiting
);

  // R5: stalled offer holds its fields
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_vec) && $stable(req_dest));

  // R10: nothing offered while a response is awaited
  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !req_valid);

  // R6: accept clears the warning
  p_warn_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && rsp_valid && rsp_accept |=> !stuck_warn);

  // R7: warning persists until a success
  p_warn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_warn && !(waiting && rsp_valid && rsp_accept) |=> stuck_warn);

  // R2: an offer always stems from a pending pin
  p_from_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> pend_q != '0);

endmodule

bind irq_redirector irq_redirector_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vec(req_vec), .req_dest(req_dest), .rsp_valid(rsp_valid),
  .rsp_accept(rsp_accept), .stuck_warn(stuck_warn), .pend_q(pend_q),
  .waiting(waiting)
);

// File: tb/test_irq_redirector.sv
module test_irq_redirector;

  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          sel_we = 1'b0, data_we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          req_valid, req_ready = 1'b0;
  logic [7:0]    req_dest, req_vec;
  logic          req_dmode, req_pol, req_trig;
  logic [2:0]    req_dlv;
  logic          rsp_valid = 1'b0, rsp_accept = 1'b0;
  logic          stuck_warn;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  irq_redirector i_irq_redirector (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sel_we(sel_we),
    .data_we(data_we), .wdata(wdata), .rdata(rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_dest(req_dest), .req_dmode(req_dmode),
    .req_dlv(req_dlv), .req_vec(req_vec), .req_pol(req_pol),
    .req_trig(req_trig), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
    .stuck_warn(stuck_warn)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] sel, input logic [31:0] v);
    sel_we = 1'b1; wdata = {24'h0, sel}; tick(); sel_we = 1'b0;
    data_we = 1'b1; wdata = v; tick(); data_we = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] sel, output logic [31:0] v);
    sel_we = 1'b1; wdata = {24'h0, sel}; tick(); sel_we = 1'b0;
    v = rdata;
  endtask

  function automatic logic [31:0] mk_lo(input bit msk, input bit trig,
      input bit rirr, input bit pol, input bit dmode, input logic [2:0] dlv,
      input logic [7:0] vec);
    return {15'h0, msk, trig, rirr, pol, 1'b0, dmode, dlv, vec};
  endfunction

  function automatic logic [7:0] lo_sel(input int n);
    return 8'(16 + 2 * n);
  endfunction

  task automatic pulse(input int n);
    pin_in[n] = 1'b1; tick(); pin_in[n] = 1'b0;
  endtask

  // Wait for an offer, compare fields, optionally stall, then complete it.
  task automatic serve(input bit acc, input logic [7:0] e_dest,
      input logic [31:0] e_lo, input int stall, input string tag);
    logic [19:0] exp_f, act_f;
    int n = 0;
    while (!req_valid && n < 40) begin tick(); n++; end
    chk(req_valid, {tag, " offer present"}, 32'(req_valid), 32'd1);
    exp_f = {e_lo[15], e_lo[13], e_lo[11], e_lo[10:8], e_lo[7:0]} ;
    act_f = {req_trig, req_pol, req_dmode, req_dlv, req_vec};
    chk(act_f[13:0] == exp_f[13:0] && req_dest == e_dest, {tag, " fields"},
        {req_dest, 10'h0, act_f[13:0]}, {e_dest, 10'h0, exp_f[13:0]});
    for (int s = 0; s < stall; s++) begin
      tick();
      chk(req_valid && req_vec == e_lo[7:0], "R5 hold under stall",
          {23'h0, req_valid, req_vec}, {23'h0, 1'b1, e_lo[7:0]});
    end
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    chk(!req_valid, "R10 no offer while awaiting", 32'(req_valid), 32'd0);
    rsp_valid = 1'b1; rsp_accept = acc; tick();
    rsp_valid = 1'b0; rsp_accept = 1'b0;
  endtask

  task automatic quiet(input int cycles, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      if (req_valid) seen = 1'b1;
      tick();
    end
    chk(!seen, tag, 32'(seen), 32'd0);
  endtask

  initial begin
    logic [31:0] v, lo_a, lo_b;
    logic [7:0]  d_a;
    void'($urandom(32'd4711));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk(!req_valid && !stuck_warn, "R1 outputs idle",
        {30'h0, req_valid, stuck_warn}, 32'h0);
    v = rdata;
    chk(v == 32'h0, "R1 select 0 / ID 0", v, 32'h0);
    for (int n = 0; n < NP; n += 7) begin
      rreg(lo_sel(n), v);
      chk(v == 32'h0001_0000, "R1 entry masked", v, 32'h0001_0000);
      rreg(lo_sel(n) + 8'd1, v);
      chk(v == 32'h0, "R1 entry high zero", v, 32'h0);
    end

    // R8: ID, version, arbitration, unused
    wreg(8'h00, 32'hA5FF_FFFF);
    rreg(8'h00, v);  chk(v == 32'hA500_0000, "R8 ID readback", v, 32'hA500_0000);
    rreg(8'h01, v);  chk(v == 32'h0017_0011, "R8 version", v, 32'h0017_0011);
    rreg(8'h02, v);  chk(v == 32'h0, "R8 arbitration zero", v, 32'h0);
    rreg(8'h05, v);  chk(v == 32'h0, "R8 unused zero", v, 32'h0);

    // R9 / R2 / R5: entry 3, status write ignored, repeat assertion
    lo_a = mk_lo(0, 1, 1, 1, 1, 3'd5, 8'h3C);
    wreg(lo_sel(3), lo_a | 32'h0000_1000);
    wreg(lo_sel(3) + 8'd1, 32'h9E00_0000);
    rreg(lo_sel(3), v);
    chk(v == lo_a, "R9 status bit read-only", v, lo_a);
    pulse(3); pulse(3);
    serve(1'b1, 8'h9E, lo_a, 2, "R5 entry3");
    quiet(10, "R2 repeat assertion gives one delivery");

    // R3: masked pin held, offered after unmask
    lo_b = mk_lo(1, 0, 0, 0, 0, 3'd1, 8'h51);
    wreg(lo_sel(5), lo_b);
    wreg(lo_sel(5) + 8'd1, 32'h0300_0000);
    pulse(5);
    quiet(12, "R3 masked pin not offered");
    lo_b[16] = 1'b0;
    wreg(lo_sel(5), lo_b);
    serve(1'b1, 8'h03, lo_b, 0, "R3 unmasked offer");
    quiet(6, "R3 retired");

    // R4: simultaneous pins, lowest first
    lo_a = mk_lo(0, 0, 0, 1, 0, 3'd0, 8'h22);
    lo_b = mk_lo(0, 1, 0, 0, 1, 3'd2, 8'h77);
    wreg(lo_sel(2), lo_a); wreg(lo_sel(2) + 8'd1, 32'h1100_0000);
    wreg(lo_sel(7), lo_b); wreg(lo_sel(7) + 8'd1, 32'h7700_0000);
    pin_in[7] = 1'b1; pin_in[2] = 1'b1; tick(); pin_in = '0;
    serve(1'b1, 8'h11, lo_a, 0, "R4 first is pin 2");
    serve(1'b1, 8'h77, lo_b, 0, "R4 second is pin 7");
    quiet(6, "R4 both retired");

    // R7 / R6: reject run then accept
    lo_a = mk_lo(0, 0, 0, 0, 0, 3'd0, 8'h40);
    wreg(lo_sel(4), lo_a); wreg(lo_sel(4) + 8'd1, 32'h0100_0000);
    pulse(4);
    for (int k = 1; k <= 6; k++) begin
      serve(1'b0, 8'h01, lo_a, 0, "R7 retry");
      chk(stuck_warn == (k > 5), "R7 warn threshold",
          32'(stuck_warn), 32'(k > 5));
    end
    rreg(lo_sel(4), v);
    chk(v[12] == 1'b1, "R7 delivery status set", v, lo_a | 32'h1000);
    serve(1'b1, 8'h01, lo_a, 0, "R6 final accept");
    chk(!stuck_warn, "R6 warn cleared", 32'(stuck_warn), 32'd0);
    rreg(lo_sel(4), v);
    chk(v == lo_a, "R6 delivery status cleared", v, lo_a);
    quiet(6, "R6 pending cleared");

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int n, nrej;
      n = $urandom_range(0, NP - 1);
      lo_a = mk_lo(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   3'($urandom), 8'($urandom));
      d_a  = 8'($urandom);
      wreg(lo_sel(n), lo_a);
      wreg(lo_sel(n) + 8'd1, {d_a, 24'h0});
      pulse(n);
      nrej = $urandom_range(0, 2);
      for (int r = 0; r < nrej; r++)
        serve(1'b0, d_a, lo_a, $urandom_range(0, 2), "R7 random reject");
      serve(1'b1, d_a, lo_a, $urandom_range(0, 3), "R5 random entry");
      rreg(lo_sel(n), v);
      chk(v == lo_a, "R6 random status clear", v, lo_a);
      wreg(lo_sel(n), lo_a | 32'h0001_0000);
    end
    quiet(8, "R2 idle after random mix");

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule